// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver with Sticky Errors

This block receives asynchronous serial frames on one input line. A tick divider makes sixteen ticks per bit time. The receiver looks for a falling start edge and checks the start bit again at mid-bit, which rejects short low glitches. It then samples eight data bits, least significant bit first, at the middle of each bit, and checks the stop bit. Each completed frame goes to a data register and to a small status register.

Software uses a two-location register port. Location 0 reads the received byte. Location 1 reads and writes status and control. The overrun and framing flags are sticky. While either flag is set, the receiver does not start a new frame. A flag clears only when software first reads the status location with the flag at 1 and then writes 0 to that bit. Read data comes back one clock after the read strobe.

Top module: `urx_top`

## Requirements
- R1: After reset, the status location reads 0x00. All flags are 0, receive-enable is 0 and one-stop-bit mode is selected.
- R2: Status bit layout: bit 0 data-full, bit 1 overrun, bit 2 framing error, bit 4 receive-enable, bit 5 two-stop-bit mode. Bits 3, 6 and 7 read 0.
- R3: With receive-enable at 1, a frame has a low start bit, eight data bits sent least significant bit first, and a high stop bit. Each bit lasts 16 ticks and is sampled at mid-bit. Such a frame loads the byte into location 0 and sets data-full.
- R4: Reading location 0 clears data-full.
- R5: When a frame completes while data-full is 1, the overrun flag sets. Location 0 keeps the earlier byte and the new byte is dropped.
- R6: While the overrun flag or the framing flag is 1, no frame is received. Location 0 and data-full do not change.
- R7: When the sampled stop bit is 0, the framing flag sets and the byte is still loaded into location 0, but data-full stays 0.
- R8: In two-stop-bit mode only the first stop bit is checked. A low second stop bit causes no error.
- R9: An error flag clears only when a status write holds 0 in its bit and no other status write has come between that write and a status read that returned the flag as 1. A write of 1 never sets a flag.
- R10: Writing receive-enable to 0 leaves both error flags unchanged. While receive-enable is 0, the line is ignored.
- R11: A low pulse on the line shorter than half a bit time does not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Serial input line, idle high |
| reg_addr | input | 1 | 0 = received byte, 1 = status and control |
| reg_rd | input | 1 | Read strobe; data is valid on reg_rdata one clock later |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |

## Verification
A table of frames is run in one-stop and two-stop modes. Each entry varies the data byte and the levels of both stop bits. Alternating, all-ones, all-zeros and single-set-bit bytes detect bit order and shift errors. The stop-bit combinations separate a clean frame, a framing error and a low second stop bit that must be ignored. Directed sequences then cover the other cases: two frames with no read in between (overrun and data retention), a frame sent while a flag is set, clear attempts without a prior read and with a 1 written, disabling the receiver while a flag is set, and a short low glitch followed by a good frame.

// File: rtl/urx_pkg.sv
package urx_pkg;
  localparam int ST_FULL = 0;
  localparam int ST_OVR  = 1;
  localparam int ST_FRM  = 2;
  localparam int ST_EN   = 4;
  localparam int ST_TWO  = 5;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP1, RX_STOP2
  } rx_state_e;
endpackage

// File: rtl/urx_tick.sv
module urx_tick #(
  parameter int CLKS_PER_TICK = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  generate
    if (CLKS_PER_TICK <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(CLKS_PER_TICK);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt  <= '0;
          tick <= 1'b0;
        end else if (cnt == CW'(CLKS_PER_TICK - 1)) begin
          cnt  <= '0;
          tick <= 1'b1;
        end else begin
          cnt  <= cnt + 1'b1;
          tick <= 1'b0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/urx_frame.sv
module urx_frame import urx_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              go,
  input  logic              two_stop,
  input  logic              rx_line,
  output logic              done,
  output logic              stop_ok,
  output logic [DATA_W-1:0] data
);
  localparam int HALF = OVS / 2;
  localparam int CNT_W = $clog2(OVS + HALF + 1);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [1:0]        sync;
  logic              rx;
  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [BW-1:0]     bidx;
  logic [DATA_W-1:0] shreg;

  assign rx = sync[1];

  always_ff @(posedge clk) begin
    if (rst) sync <= 2'b11;
    else     sync <= {sync[0], rx_line};
  end

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst || !go) begin
      state <= RX_IDLE;
      cnt   <= '0;
      bidx  <= '0;
      if (rst) begin
        shreg   <= '0;
        data    <= '0;
        stop_ok <= 1'b0;
      end
    end else if (tick) begin
      cnt <= cnt + 1'b1;
      case (state)
        RX_IDLE: begin
          cnt <= '0;
          if (!rx) state <= RX_START;
        end
        RX_START: begin
          if (cnt == CNT_W'(HALF - 1)) begin
            cnt   <= '0;
            bidx  <= '0;
            state <= rx ? RX_IDLE : RX_DATA;
          end
        end
        RX_DATA: begin
          if (cnt == CNT_W'(OVS - 1)) begin
            cnt   <= '0;
            shreg <= {rx, shreg[DATA_W-1:1]};
            if (bidx == BW'(DATA_W - 1)) state <= RX_STOP1;
            else                         bidx  <= bidx + 1'b1;
          end
        end
        RX_STOP1: begin
          if (cnt == CNT_W'(OVS - 1)) begin
            cnt     <= '0;
            done    <= 1'b1;
            data    <= shreg;
            stop_ok <= rx;
            state   <= two_stop ? RX_STOP2 : RX_IDLE;
          end
        end
        RX_STOP2: begin
          if (cnt == CNT_W'(OVS + HALF - 1)) begin
            cnt   <= '0;
            state <= RX_IDLE;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/urx_regs.sv
module urx_regs import urx_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_done,
  input  logic              frame_ok,
  input  logic [DATA_W-1:0] frame_data,
  input  logic              reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic [DATA_W-1:0] rdr,
  output logic              st_full,
  output logic              st_ovr,
  output logic              st_frm,
  output logic              rx_en,
  output logic              two_stop,
  output logic              go
);
  logic seen_ovr, seen_frm;
  logic st_rd, st_wr, dat_rd;

  assign st_rd  = reg_rd && reg_addr;
  assign st_wr  = reg_wr && reg_addr;
  assign dat_rd = reg_rd && !reg_addr;
  assign go     = rx_en && !st_ovr && !st_frm;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdr      <= '0;
      st_full  <= 1'b0;
      st_ovr   <= 1'b0;
      st_frm   <= 1'b0;
      rx_en    <= 1'b0;
      two_stop <= 1'b0;
      seen_ovr <= 1'b0;
      seen_frm <= 1'b0;
    end else begin
      if (dat_rd) st_full <= 1'b0;
      if (st_wr) begin
        rx_en    <= reg_wdata[ST_EN];
        two_stop <= reg_wdata[ST_TWO];
        seen_ovr <= 1'b0;
        seen_frm <= 1'b0;
        if (seen_ovr && !reg_wdata[ST_OVR]) st_ovr <= 1'b0;
        if (seen_frm && !reg_wdata[ST_FRM]) st_frm <= 1'b0;
      end else if (st_rd) begin
        seen_ovr <= st_ovr;
        seen_frm <= st_frm;
      end
      if (frame_done) begin
        if (st_full) begin
          st_ovr <= 1'b1;
        end else if (!frame_ok) begin
          rdr    <= frame_data;
          st_frm <= 1'b1;
        end else begin
          rdr     <= frame_data;
          st_full <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      reg_rdata <= '0;
      if (reg_addr) begin
        reg_rdata[ST_FULL] <= st_full;
        reg_rdata[ST_OVR]  <= st_ovr;
        reg_rdata[ST_FRM]  <= st_frm;
        reg_rdata[ST_EN]   <= rx_en;
        reg_rdata[ST_TWO]  <= two_stop;
      end else begin
        reg_rdata <= 8'(rdr);
      end
    end
  end
endmodule

// File: rtl/urx_top.sv
module urx_top #(
  parameter int CLKS_PER_TICK = 4,
  parameter int OVS           = 16,
  parameter int DATA_W        = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_line,
  input  logic       reg_addr,
  input  logic       reg_rd,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata
);
  logic              tick, go, two_stop, rx_en;
  logic              frame_done, frame_ok;
  logic [DATA_W-1:0] frame_data, rdr;
  logic              st_full, st_ovr, st_frm;

  urx_tick #(.CLKS_PER_TICK(CLKS_PER_TICK)) tick_i (
    .clk(clk), .rst(rst), .tick(tick)
  );

  urx_frame #(.DATA_W(DATA_W), .OVS(OVS)) frame_i (
    .clk(clk), .rst(rst), .tick(tick), .go(go), .two_stop(two_stop),
    .rx_line(rx_line), .done(frame_done), .stop_ok(frame_ok),
    .data(frame_data)
  );

  urx_regs #(.DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst(rst), .frame_done(frame_done), .frame_ok(frame_ok),
    .frame_data(frame_data), .reg_addr(reg_addr), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rdr(rdr), .st_full(st_full), .st_ovr(st_ovr), .st_frm(st_frm),
    .rx_en(rx_en), .two_stop(two_stop), .go(go)
  );
endmodule

// File: rtl/urx_chk.sv
module urx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_done,
  input logic              frame_ok,
  input logic [DATA_W-1:0] frame_data,
  input logic [DATA_W-1:0] rdr,
  input logic              st_full,
  input logic              st_ovr,
  input logic              st_frm
);
  AST_GOOD_FRAME_LOADS: assert property (@(posedge clk) disable iff (rst)
    frame_done && !st_full && frame_ok |=> st_full && rdr == $past(frame_data)); // R3
  AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (rst)
    frame_done && st_full |=> st_ovr && $stable(rdr)); // R5
  AST_NO_FRAME_WHILE_ERR: assert property (@(posedge clk) disable iff (rst)
    (st_ovr || st_frm) |-> !frame_done); // R6
  AST_FRM_NO_FULL: assert property (@(posedge clk) disable iff (rst)
    frame_done && !st_full && !frame_ok |=> st_frm && !st_full && rdr == $past(frame_data)); // R7
  AST_OVR_ONLY_BY_FRAME: assert property (@(posedge clk) disable iff (rst)
    !st_ovr && !frame_done |=> !st_ovr); // R9
  AST_FRM_ONLY_BY_FRAME: assert property (@(posedge clk) disable iff (rst)
    !st_frm && !frame_done |=> !st_frm); // R9
endmodule

bind urx_top urx_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .frame_done(frame_done), .frame_ok(frame_ok),
  .frame_data(frame_data), .rdr(rdr), .st_full(st_full),
  .st_ovr(st_ovr), .st_frm(st_frm)
);

// File: tb/urx_top_tb_top.sv
`timescale 1ns/1ps
module urx_top_tb_top;
  localparam int CPT = 4;
  localparam int BITCLK = CPT * 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_line = 1'b1;
  logic       reg_addr = 1'b0;
  logic       reg_rd = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  urx_top #(.CLKS_PER_TICK(CPT)) dut_i (
    .clk(clk), .rst(rst), .rx_line(rx_line), .reg_addr(reg_addr),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  // vector: {data[7:0], stop1, stop2, two_stop}
  localparam int NV = 6;
  localparam logic [10:0] VEC [NV] = '{
    {8'hA5, 1'b1, 1'b1, 1'b0},
    {8'h3C, 1'b0, 1'b1, 1'b0},
    {8'h01, 1'b1, 1'b0, 1'b1},
    {8'h80, 1'b0, 1'b1, 1'b1},
    {8'hFF, 1'b1, 1'b1, 1'b0},
    {8'h00, 1'b1, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; v = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); reg_addr = 1'b1; reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic line_for(input logic lvl, input int n);
    @(negedge clk); rx_line = lvl;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic s1, input logic s2, input logic two);
    line_for(1'b0, BITCLK);
    for (int i = 0; i < 8; i++) line_for(d[i], BITCLK);
    line_for(s1, BITCLK);
    if (two) line_for(s2, BITCLK);
    line_for(1'b1, 2 * BITCLK);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    rd(1'b1, v); check("R1 reset status", v, 8'h00);
    rd(1'b0, v); check("R1 reset data", v, 8'h00);

    // table walk (R2 R3 R4 R7 R8)
    for (int k = 0; k < NV; k++) begin
      logic [7:0] d;
      logic s1, s2, two;
      logic [7:0] exp_st;
      {d, s1, s2, two} = VEC[k];
      wr({2'b00, two, 1'b1, 4'b0000});
      send(d, s1, s2, two);
      exp_st = {2'b00, two, 1'b1, 1'b0, !s1, 1'b0, s1};
      rd(1'b1, v); check(s1 ? "R3 R8 status good frame" : "R7 status framing", v, exp_st);
      rd(1'b0, v); check("R3 R7 data loaded", v, d);
      rd(1'b1, v); check("R4 full cleared by data read", v, {exp_st[7:1], 1'b0});
      if (!s1) begin
        wr({2'b00, two, 1'b1, 4'b0000});
        rd(1'b1, v); check("R9 framing cleared", v, {2'b00, two, 1'b1, 4'b0000});
      end
    end

    // overrun R5, blocking R6, clear rule R9
    wr(8'h10);
    send(8'h11, 1'b1, 1'b1, 1'b0);
    send(8'h22, 1'b1, 1'b1, 1'b0);
    rd(1'b1, v); check("R5 overrun status", v, 8'h13);
    rd(1'b0, v); check("R5 earlier byte kept", v, 8'h11);
    send(8'h33, 1'b1, 1'b1, 1'b0);
    rd(1'b1, v); check("R6 no frame while overrun", v, 8'h12);
    rd(1'b0, v); check("R6 data unchanged", v, 8'h11);
    wr(8'h16);
    wr(8'h10);
    rd(1'b1, v); check("R9 write 0 without read ignored", v, 8'h12);
    wr(8'h10);
    rd(1'b1, v); check("R9 read then write 0 clears", v, 8'h10);
    wr(8'h12);
    rd(1'b1, v); check("R9 write 1 never sets", v, 8'h10);

    // disable R10
    send(8'h44, 1'b0, 1'b1, 1'b0);
    rd(1'b1, v); check("R7 framing set", v, 8'h14);
    wr(8'h06);
    rd(1'b1, v); check("R10 disable keeps framing flag", v, 8'h04);
    wr(8'h00);
    rd(1'b1, v); check("R9 framing cleared", v, 8'h00);
    send(8'h55, 1'b1, 1'b1, 1'b0);
    rd(1'b1, v); check("R10 line ignored when disabled", v, 8'h00);
    rd(1'b0, v); check("R10 data untouched when disabled", v, 8'h44);

    // glitch R11
    wr(8'h10);
    line_for(1'b0, BITCLK / 4);
    line_for(1'b1, 3 * BITCLK);
    rd(1'b1, v); check("R11 glitch rejected", v, 8'h10);
    send(8'h5A, 1'b1, 1'b1, 1'b0);
    rd(1'b1, v); check("R11 frame after glitch", v, 8'h11);
    rd(1'b0, v); check("R3 frame after glitch data", v, 8'h5A);
    rd(1'b1, v); check("R2 unused status bits zero", v & 8'hC8, 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule